// File: doc/BRIEF.md
# Byte-Strobe Checked Register File

This block is a small memory-mapped register file behind a simple request interface: a valid flag, a byte address, a write flag, 32 bits of write data and a 4-bit byte strobe. It answers in the same cycle with read data, a ready flag that is always high, and an error flag. Each word holds one or more fields at fixed bit ranges. Several narrow registers can share one word address. They are packed at byte-aligned positions that run upward from bit 0, and each member's width is rounded up to whole bytes.

A strobed write updates only those fields that have at least one byte selected. A write is rejected when the strobe would update only part of a field. The check finds the byte positions where the strobe pattern switches between on and off. It compares those positions with the byte boundaries that some field in the addressed word straddles. Any overlap flags an error, and no field of that word changes.

Top module: `rf_strobe_regs`

## Requirements
- R1: After the asynchronous active-low reset, the words read as follows:
  - 0x00 reads 0x00A51234.
  - 0x04 reads 0x0000F003.
  - 0x08 reads 0x00000001.
  - 0x0C reads 0x80000000.
- R2: A write with all four strobe bits set to a mapped word updates every field of that word from the write data. The write reports no error.
- R3: A field none of whose bytes is strobed keeps its value. Strobe bit i selects bits 8i+7:8i. Word 0x00 holds bits 15:0 and 23:16. Word 0x0C holds bits 31:16.
- R4: The write is rejected when a strobe edge meets a byte boundary spanned by a field of the addressed word.
  - An edge at position k is bit k of (strb ^ (strb >> 1)), for k = 0..2.
  - When rejected, the error flag rises in the same cycle and no field of the word changes.
  - Example: strobe 0100 to word 0x0C is rejected.
- R5: A strobe that covers some fields of a word completely and leaves others untouched is accepted. Example: strobe 0100 to word 0x00 writes only bits 23:16.
- R6: Word 0x04 packs three registers of 4, 12 and 8 bits. They sit at bits 3:0, 19:8 and 31:24, and the remaining bits read zero. A strobe whose edges fall inside bytes 1..2 is rejected.
- R7: A valid access to an address that matches no word returns an error and read data zero, and changes no field. This includes misaligned addresses.
- R8: Ready is always high. A read of a mapped word reports no error, and no error is reported while valid is low.
- R9: A write with an all-zero strobe to a mapped word reports no error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request |
| req_addr_i | input | ADDR_W | Byte address |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 32 | Write data |
| req_strb_i | input | 4 | Byte strobe, bit i selects byte i |
| rsp_rdata_o | output | 32 | Read data, zero when no word matches |
| rsp_ready_o | output | 1 | Always high |
| rsp_error_o | output | 1 | Unmapped address or partial-field write |

## Verification
The assertions assume that the request inputs are stable around each rising edge, and that at most one word decoder matches a given address. The assertions also assume that a field's enable alone decides whether it is loaded. The stimulus changes inputs only on the falling edge and samples the combinational response in the low phase, before the next rising edge. It uses only aligned or deliberately misaligned byte addresses inside the address width. Strobe patterns are chosen per word so that each side of each spanned boundary is hit, both with an accepting edge and with a rejecting edge.

// File: rtl/rf_strobe_pkg.sv
package rf_strobe_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned STRB_W     = DATA_W / 8;
  localparam int unsigned EDGE_W     = STRB_W - 1;
  localparam int unsigned NUM_WORDS  = 4;
  localparam int unsigned NUM_FIELDS = 7;

  // Field table: owning word, width, fixed base (unpacked only), packed flag, reset value
  localparam int unsigned FLD_WORD   [NUM_FIELDS] = '{0, 0, 1, 1, 1, 2, 3};
  localparam int unsigned FLD_WID    [NUM_FIELDS] = '{16, 8, 4, 12, 8, 32, 16};
  localparam int unsigned FLD_BASE   [NUM_FIELDS] = '{0, 16, 0, 0, 0, 0, 16};
  localparam bit          FLD_PACKED [NUM_FIELDS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [DATA_W-1:0] FLD_RST [NUM_FIELDS] =
    '{32'h0000_1234, 32'h0000_00A5, 32'h0000_0003, 32'h0000_00F0,
      32'h0000_0000, 32'h0000_0001, 32'h0000_8000};

  // Packed members start at the running sum of earlier members' byte-rounded widths
  function automatic int unsigned field_lsb(int unsigned idx);
    int unsigned off;
    off = 0;
    if (!FLD_PACKED[idx]) return FLD_BASE[idx];
    for (int unsigned j = 0; j < idx; j++)
      if (FLD_PACKED[j] && FLD_WORD[j] == FLD_WORD[idx])
        off += (FLD_WID[j] + 7) / 8 * 8;
    return off;
  endfunction

  // One bit per byte lane touched by bits lsb .. lsb+wid-1
  function automatic logic [STRB_W-1:0] byte_mask(int unsigned lsb, int unsigned wid);
    logic [STRB_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < STRB_W; b++)
      if (lsb <= 8 * b + 7 && lsb + wid - 1 >= 8 * b) m[b] = 1'b1;
    return m;
  endfunction

  // Bit k: strobe changes between byte k and byte k+1
  function automatic logic [EDGE_W-1:0] strobe_edges(logic [STRB_W-1:0] be);
    logic [STRB_W-1:0] t;
    t = be ^ (be >> 1);
    return t[EDGE_W-1:0];
  endfunction

  // Bit k: some field of word w straddles the boundary above byte k
  function automatic logic [EDGE_W-1:0] word_crossings(int unsigned w);
    logic [EDGE_W-1:0] c;
    logic [STRB_W-1:0] m;
    logic [STRB_W-1:0] t;
    c = '0;
    for (int unsigned i = 0; i < NUM_FIELDS; i++)
      if (FLD_WORD[i] == w) begin
        m = byte_mask(field_lsb(i), FLD_WID[i]);
        t = m & (m >> 1);
        c |= t[EDGE_W-1:0];
      end
    return c;
  endfunction
endpackage

// File: rtl/rf_field.sv
module rf_field
  import rf_strobe_pkg::*;
#(
  parameter int unsigned LSB = 0,
  parameter int unsigned WID = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [WID-1:0]    value_o
);
  logic [WID-1:0] slice;
  assign slice = wdata_i[LSB +: WID];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) value_o <= RST_VAL[WID-1:0];
    else if (we_i) value_o <= slice;
  end

  assert_field_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> value_o == $past(slice));
  assert_field_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(value_o));
endmodule

// File: rtl/rf_decode.sv
module rf_decode
  import rf_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 req_write_i,
  input  logic [STRB_W-1:0]    req_strb_i,
  output logic [NUM_WORDS-1:0] word_hit_o,
  output logic                 any_hit_o,
  output logic                 part_err_o
);
  logic [EDGE_W-1:0] cross_sel [NUM_WORDS];
  logic [EDGE_W-1:0] cross_any;
  logic [EDGE_W-1:0] edges;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [EDGE_W-1:0] XMASK = word_crossings(g);
    assign word_hit_o[g] = (req_addr_i == ADDR_W'(g * STRB_W));
    assign cross_sel[g]  = word_hit_o[g] ? XMASK : '0;
  end

  always_comb begin
    cross_any = '0;
    for (int i = 0; i < NUM_WORDS; i++) cross_any |= cross_sel[i];
  end

  assign edges      = strobe_edges(req_strb_i);
  assign any_hit_o  = |word_hit_o;
  assign part_err_o = req_valid_i & req_write_i & (|(edges & cross_any));

  assert_onehot_hit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(word_hit_o));
  assert_err_needs_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_err_o |-> any_hit_o && req_write_i);
endmodule

// File: rtl/rf_strobe_regs.sv
module rf_strobe_regs
  import rf_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [3:0]        req_strb_i,
  output logic [31:0]       rsp_rdata_o,
  output logic              rsp_ready_o,
  output logic              rsp_error_o
);
  logic [NUM_WORDS-1:0]  word_hit;
  logic                  any_hit;
  logic                  part_err;
  logic [NUM_FIELDS-1:0] fld_we;
  logic [DATA_W-1:0]     fld_pos [NUM_FIELDS];
  logic                  unmapped;

  rf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .req_strb_i  (req_strb_i),
    .word_hit_o  (word_hit),
    .any_hit_o   (any_hit),
    .part_err_o  (part_err)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam int unsigned LSB  = field_lsb(g);
    localparam int unsigned WID  = FLD_WID[g];
    localparam int unsigned WORD = FLD_WORD[g];
    localparam logic [STRB_W-1:0] BMASK = byte_mask(LSB, WID);
    logic [WID-1:0] q;

    assign fld_we[g] = req_valid_i & req_write_i & word_hit[WORD] & ~part_err
                     & (|(BMASK & req_strb_i));

    rf_field #(.LSB(LSB), .WID(WID), .RST_VAL(FLD_RST[g])) u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (fld_we[g]),
      .wdata_i (req_wdata_i),
      .value_o (q)
    );

    assign fld_pos[g] = word_hit[WORD] ? (DATA_W'(q) << LSB) : '0;
  end

  always_comb begin
    rsp_rdata_o = '0;
    for (int i = 0; i < NUM_FIELDS; i++) rsp_rdata_o |= fld_pos[i];
  end

  assign unmapped    = req_valid_i & ~any_hit;
  assign rsp_ready_o = 1'b1;
  assign rsp_error_o = unmapped | part_err;

  assert_no_write_on_error_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fld_we) |-> !rsp_error_o);
  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !any_hit) |-> rsp_rdata_o == '0 && fld_we == '0);
  assert_empty_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_strb_i == '0 && any_hit) |-> !rsp_error_o && fld_we == '0);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !rsp_error_o && fld_we == '0);
endmodule

// File: tb/rf_strobe_regs_tb.sv
module rf_strobe_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  strb = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        err;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rf_strobe_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_addr_i(addr),
    .req_write_i(wr), .req_wdata_i(wdata), .req_strb_i(strb),
    .rsp_rdata_o(rdata), .rsp_ready_o(ready), .rsp_error_o(err));

  // {req(4), write(1), addr(8), wdata(32), strb(4), exp_err(1), exp_rdata(32)}
  localparam int NV = 35;
  localparam logic [81:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00A51234},       // R1
    {4'd1, 1'b0, 8'h04, 32'h0, 4'h0, 1'b0, 32'h0000F003},       // R1
    {4'd1, 1'b0, 8'h08, 32'h0, 4'h0, 1'b0, 32'h00000001},       // R1
    {4'd1, 1'b0, 8'h0C, 32'h0, 4'h0, 1'b0, 32'h80000000},       // R1
    {4'd2, 1'b1, 8'h00, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0},       // R2
    {4'd2, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00FFFFFF},       // R2
    {4'd3, 1'b1, 8'h00, 32'h11223344, 4'h3, 1'b0, 32'h0},       // R3
    {4'd3, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00FF3344},       // R3
    {4'd4, 1'b1, 8'h00, 32'hAABBCCDD, 4'h1, 1'b1, 32'h0},       // R4
    {4'd4, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00FF3344},       // R4
    {4'd5, 1'b1, 8'h00, 32'h55667788, 4'h4, 1'b0, 32'h0},       // R5
    {4'd5, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00663344},       // R5
    {4'd6, 1'b1, 8'h04, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0},       // R6
    {4'd6, 1'b0, 8'h04, 32'h0, 4'h0, 1'b0, 32'hFF0FFF0F},       // R6
    {4'd5, 1'b1, 8'h04, 32'h12345678, 4'h1, 1'b0, 32'h0},       // R5
    {4'd5, 1'b1, 8'h04, 32'hAB000000, 4'h8, 1'b0, 32'h0},       // R5
    {4'd6, 1'b1, 8'h04, 32'h00012300, 4'h4, 1'b1, 32'h0},       // R6
    {4'd6, 1'b1, 8'h04, 32'h00000100, 4'h2, 1'b1, 32'h0},       // R6
    {4'd6, 1'b1, 8'h04, 32'h00ABCD00, 4'h6, 1'b0, 32'h0},       // R6
    {4'd6, 1'b0, 8'h04, 32'h0, 4'h0, 1'b0, 32'hAB0BCD08},       // R6
    {4'd4, 1'b1, 8'h0C, 32'h12345678, 4'h4, 1'b1, 32'h0},       // R4
    {4'd3, 1'b1, 8'h0C, 32'h12345678, 4'h1, 1'b0, 32'h0},       // R3
    {4'd3, 1'b0, 8'h0C, 32'h0, 4'h0, 1'b0, 32'h80000000},       // R3
    {4'd2, 1'b1, 8'h0C, 32'h9ABC0000, 4'hC, 1'b0, 32'h0},       // R2
    {4'd2, 1'b0, 8'h0C, 32'h0, 4'h0, 1'b0, 32'h9ABC0000},       // R2
    {4'd4, 1'b1, 8'h08, 32'hCAFEF00D, 4'hA, 1'b1, 32'h0},       // R4
    {4'd4, 1'b0, 8'h08, 32'h0, 4'h0, 1'b0, 32'h00000001},       // R4
    {4'd2, 1'b1, 8'h08, 32'hCAFEF00D, 4'hF, 1'b0, 32'h0},       // R2
    {4'd2, 1'b0, 8'h08, 32'h0, 4'h0, 1'b0, 32'hCAFEF00D},       // R2
    {4'd9, 1'b1, 8'h00, 32'hFFFFFFFF, 4'h0, 1'b0, 32'h0},       // R9
    {4'd9, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00663344},       // R9
    {4'd7, 1'b0, 8'h10, 32'h0, 4'h0, 1'b1, 32'h0},              // R7
    {4'd7, 1'b0, 8'h02, 32'h0, 4'h0, 1'b1, 32'h0},              // R7
    {4'd7, 1'b1, 8'h10, 32'hFFFFFFFF, 4'hF, 1'b1, 32'h0},       // R7
    {4'd7, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00663344}        // R7
  };

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic xe, input logic [31:0] xr, input int req);
    @(negedge clk);
    valid = 1'b1; wr = w; addr = a; wdata = d; strb = s;
    #2;
    check(ready == 1'b1, 8, {31'b0, ready}, 32'h1);
    check(err == xe, req, {31'b0, err}, {31'b0, xe});
    if (!w) check(rdata == xr, req, rdata, xr);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      access(VEC[i][77], VEC[i][76:69], VEC[i][68:37], VEC[i][36:33],
             VEC[i][32], VEC[i][31:0], int'(VEC[i][81:78]));
    // R8: idle with an unmapped address raises no error
    @(negedge clk);
    valid = 1'b0; wr = 1'b1; addr = 8'h10; strb = 4'hF;
    #2;
    check(err == 1'b0, 8, {31'b0, err}, 32'h0);
    // R1: reset mid-run restores reset values
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 8'h00, 32'h0, 4'h0, 1'b0, 32'h00A51234, 1);
    access(1'b0, 8'h04, 32'h0, 4'h0, 1'b0, 32'h0000F003, 1);
    access(1'b0, 8'h08, 32'h0, 4'h0, 1'b0, 32'h00000001, 1);
    access(1'b0, 8'h0C, 32'h0, 4'h0, 1'b0, 32'h80000000, 1);
    @(negedge clk);
    valid = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule